// File: doc/BRIEF.md
# Dual-Bank Bus Exchanger with Holding Stores

The block passes words between one shared port, A, and two bank ports, 1B and 2B. In the A-to-bank direction, each bank has its own holding store, loaded from A. The shared A word can therefore be split across two banks, for example address on one bank and data on the other, or alternate words into interleaved memories. In the bank-to-A direction, each bank has its own store as well, and a select input picks which of those two stores drives A. Two banks can therefore be merged onto one path.

Each store is transparent while its load enable is high. When the enable goes low, the store keeps its word. The block is clocked. A store is written on every rising clock edge at which its enable is high, and while the enable is high its output passes the store input straight through. Each port has a separate input word, a separate output word and a drive flag. The drive flag comes from an active-low output enable. The output word always shows the contents of its store, and the drive flag only tells the surrounding pad logic whether to drive that word or release the wire.

Top module: `bus_exchanger_latch`

## Requirements
- R1: An asynchronous active-low reset clears all four stores, so that with every load enable low all three output words read zero.
- R2: While a load enable is high, the output of that path equals the path's input in the same cycle, with no clock delay.
- R3: When a load enable goes low, the path output holds the input word sampled at the last rising clock edge at which the enable was high. It stays unchanged while the input keeps changing and the enable stays low.
- R4: The store from A to 1B is loaded by `ld_a2b1` and the store from A to 2B by `ld_a2b2`. Loading one leaves the other bank's output unchanged.
- R5: The store that takes 1B toward A is loaded by `ld_b1a` and the store that takes 2B toward A by `ld_b2a`. Each is loaded independently of the other.
- R6: `a_pick` = 1 routes the 1B-side store to `a_out`, and `a_pick` = 0 routes the 2B-side store. Changing `a_pick` alters no store contents.
- R7: Output enables are active low: `a_drv`, `b1_drv` and `b2_drv` are the inverse of `a_en_n`, `b1_en_n` and `b2_en_n`. The output word is presented whatever the enable.
- R8: The bank enables are independent. Releasing one bank leaves the other bank's drive flag and word unchanged.
- R9: All four paths can load and hold at the same time in both directions without affecting one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores are written on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Word arriving on the shared port |
| b1_in | input | W | Word arriving on bank 1 |
| b2_in | input | W | Word arriving on bank 2 |
| ld_a2b1 | input | 1 | Load enable, A to bank 1 store |
| ld_a2b2 | input | 1 | Load enable, A to bank 2 store |
| ld_b1a | input | 1 | Load enable, bank 1 to A-side store |
| ld_b2a | input | 1 | Load enable, bank 2 to A-side store |
| a_pick | input | 1 | 1 selects bank 1 store onto A, 0 selects bank 2 store |
| a_en_n | input | 1 | Active-low output enable for A |
| b1_en_n | input | 1 | Active-low output enable for bank 1 |
| b2_en_n | input | 1 | Active-low output enable for bank 2 |
| a_out | output | W | Word presented toward A |
| b1_out | output | W | Word presented toward bank 1 |
| b2_out | output | W | Word presented toward bank 2 |
| a_drv | output | 1 | High when A should be driven |
| b1_drv | output | 1 | High when bank 1 should be driven |
| b2_drv | output | 1 | High when bank 2 should be driven |

## Verification
The hold properties assume that the inputs settle between clock edges. They also assume that a store's capture is defined by the last rising edge with its enable high, not by the instant the enable falls. The stimulus therefore changes every input only near the falling clock edge, and it keeps each enable high across at least one rising edge before dropping it. The select-hold property applies only when both `a_pick` and the chosen enable have been steady for a cycle, and the directed sequences switch `a_pick` only while both A-side stores are holding.

// File: rtl/exch_pkg.sv
package exch_pkg;

    typedef enum logic {
        PICK_BANK2 = 1'b0,
        PICK_BANK1 = 1'b1
    } pick_e;

    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned IDX_B1    = 0;
    localparam int unsigned IDX_B2    = 1;
    localparam int unsigned IDX_A     = 2;

endpackage

// File: rtl/exch_store.sv
module exch_store #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] hold;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.hold = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // transparent while loading, otherwise the kept word
    assign q = ld ? d : st_q.hold;

endmodule

// File: rtl/exch_pick_mux.sv
module exch_pick_mux #(
    parameter int unsigned W = 12
) (
    input  exch_pkg::pick_e pick,
    input  logic [W-1:0]    from_b1,
    input  logic [W-1:0]    from_b2,
    output logic [W-1:0]    y
);

    always_comb begin
        unique case (pick)
            exch_pkg::PICK_BANK1: y = from_b1;
            default:              y = from_b2;
        endcase
    end

endmodule

// File: rtl/exch_drive_ctl.sv
module exch_drive_ctl #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] en_n,
    output logic [N-1:0] drv
);

    for (genvar i = 0; i < N; i++) begin : g_drv
        assign drv[i] = ~en_n[i];
    end

endmodule

// File: rtl/bus_exchanger_latch.sv
module bus_exchanger_latch #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         ld_a2b1,
    input  logic         ld_a2b2,
    input  logic         ld_b1a,
    input  logic         ld_b2a,
    input  logic         a_pick,
    input  logic         a_en_n,
    input  logic         b1_en_n,
    input  logic         b2_en_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b2_out,
    output logic         a_drv,
    output logic         b1_drv,
    output logic         b2_drv
);

    import exch_pkg::*;

    localparam int unsigned NB = NUM_BANKS;
    localparam int unsigned NP = NUM_PORTS;

    logic [NB-1:0] ld_to_bank;
    logic [NB-1:0] ld_to_a;
    logic [W-1:0]  bank_in  [NB];
    logic [W-1:0]  toward_b [NB];
    logic [W-1:0]  toward_a [NB];
    logic [NP-1:0] en_n_vec;
    logic [NP-1:0] drv_vec;

    assign ld_to_bank[IDX_B1] = ld_a2b1;
    assign ld_to_bank[IDX_B2] = ld_a2b2;
    assign ld_to_a[IDX_B1]    = ld_b1a;
    assign ld_to_a[IDX_B2]    = ld_b2a;
    assign bank_in[IDX_B1]    = b1_in;
    assign bank_in[IDX_B2]    = b2_in;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        exch_store #(.W(W)) u_a2b (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld_to_bank[g]),
            .d     (a_in),
            .q     (toward_b[g])
        );
        exch_store #(.W(W)) u_b2a (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld_to_a[g]),
            .d     (bank_in[g]),
            .q     (toward_a[g])
        );
    end

    exch_pick_mux #(.W(W)) u_pick (
        .pick    (pick_e'(a_pick)),
        .from_b1 (toward_a[IDX_B1]),
        .from_b2 (toward_a[IDX_B2]),
        .y       (a_out)
    );

    assign en_n_vec[IDX_B1] = b1_en_n;
    assign en_n_vec[IDX_B2] = b2_en_n;
    assign en_n_vec[IDX_A]  = a_en_n;

    exch_drive_ctl #(.N(NP)) u_drv (
        .en_n (en_n_vec),
        .drv  (drv_vec)
    );

    assign b1_out = toward_b[IDX_B1];
    assign b2_out = toward_b[IDX_B2];
    assign b1_drv = drv_vec[IDX_B1];
    assign b2_drv = drv_vec[IDX_B2];
    assign a_drv  = drv_vec[IDX_A];

endmodule

// File: rtl/exch_checker.sv
module exch_checker #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b2_in,
    input logic         ld_a2b1,
    input logic         ld_a2b2,
    input logic         ld_b1a,
    input logic         ld_b2a,
    input logic         a_pick,
    input logic         a_en_n,
    input logic         b1_en_n,
    input logic         b2_en_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b1_out,
    input logic [W-1:0] b2_out,
    input logic         a_drv,
    input logic         b1_drv,
    input logic         b2_drv
);

    // R3 / R4: a bank store keeps its word while its load stays low
    assert_hold_b1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a2b1 && $past(!ld_a2b1)) |-> $stable(b1_out));

    assert_hold_b2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a2b2 && $past(!ld_a2b2)) |-> $stable(b2_out));

    // R3: on the falling load, the held word is the last sampled input
    assert_capture_b1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_a2b1) |-> (b1_out == $past(a_in)));

    // R2: transparent path
    assert_follow_b2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a2b2 |-> (b2_out == a_in));

    // R6 / R5: A side holds the picked store when nothing changes
    assert_pick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pick && $past(a_pick) && !ld_b1a && $past(!ld_b1a)) |-> $stable(a_out));

    assert_pick2_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_pick && $past(!a_pick) && !ld_b2a && $past(!ld_b2a)) |-> $stable(a_out));

    // R7 / R8: active-low enables, independent per port
    assert_drive_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_en_n |-> !a_drv);

    assert_drive_banks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_drv == !b1_en_n) && (b2_drv == !b2_en_n));

endmodule

bind bus_exchanger_latch exch_checker #(.W(W)) u_exch_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b1_in   (b1_in),
    .b2_in   (b2_in),
    .ld_a2b1 (ld_a2b1),
    .ld_a2b2 (ld_a2b2),
    .ld_b1a  (ld_b1a),
    .ld_b2a  (ld_b2a),
    .a_pick  (a_pick),
    .a_en_n  (a_en_n),
    .b1_en_n (b1_en_n),
    .b2_en_n (b2_en_n),
    .a_out   (a_out),
    .b1_out  (b1_out),
    .b2_out  (b2_out),
    .a_drv   (a_drv),
    .b1_drv  (b1_drv),
    .b2_drv  (b2_drv)
);

// File: tb/bus_exchanger_latch_bench.sv
module bus_exchanger_latch_bench;

    localparam int unsigned W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         ld_a2b1 = 1'b0, ld_a2b2 = 1'b0, ld_b1a = 1'b0, ld_b2a = 1'b0;
    logic         a_pick = 1'b0;
    logic         a_en_n = 1'b1, b1_en_n = 1'b1, b2_en_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drv, b1_drv, b2_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_exchanger_latch #(.W(W)) u_bus_exchanger_latch (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld_a2b1(ld_a2b1), .ld_a2b2(ld_a2b2), .ld_b1a(ld_b1a), .ld_b2a(ld_b2a),
        .a_pick(a_pick), .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n),
        .a_out(a_out), .b1_out(b1_out), .b2_out(b2_out),
        .a_drv(a_drv), .b1_drv(b1_drv), .b2_drv(b2_drv)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // move to just after the next falling edge, where inputs change
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        chk("R1 a_out", a_out, '0);
        chk("R1 b1_out", b1_out, '0);
        chk("R1 b2_out", b2_out, '0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_transparent();
        ld_a2b1 = 1'b1; a_in = 12'h5A3;
        #1 chk("R2 b1 follows", b1_out, 12'h5A3);
        a_in = 12'h0F1;
        #1 chk("R2 b1 follows new", b1_out, 12'h0F1);
        chk("R4 b2 untouched", b2_out, '0);
        step();
        ld_a2b1 = 1'b0;
        step();
    endtask

    task automatic t_capture();
        ld_a2b2 = 1'b1; a_in = 12'h9C4;
        step();                       // rising edge loaded 9C4
        ld_a2b2 = 1'b0; a_in = 12'h111;
        #1 chk("R3 b2 holds", b2_out, 12'h9C4);
        step(); a_in = 12'hEEE;
        step();
        chk("R3 b2 still holds", b2_out, 12'h9C4);
        chk("R4 b1 kept", b1_out, 12'h0F1);
    endtask

    task automatic t_b_side();
        ld_b1a = 1'b1; b1_in = 12'h321;
        ld_b2a = 1'b1; b2_in = 12'hABC;
        step();
        ld_b1a = 1'b0; b1_in = 12'h000;
        step();
        ld_b2a = 1'b0; b2_in = 12'h777;
        a_pick = 1'b1;
        #1 chk("R5 b1 store", a_out, 12'h321);
        a_pick = 1'b0;
        #1 chk("R5 b2 store", a_out, 12'hABC);
        step();
    endtask

    task automatic t_pick();
        a_pick = 1'b1;
        step();
        chk("R6 pick=1", a_out, 12'h321);
        a_pick = 1'b0;
        step();
        chk("R6 pick=0", a_out, 12'hABC);
        a_pick = 1'b1;
        step();
        chk("R6 back to 1", a_out, 12'h321);
    endtask

    task automatic t_enables();
        a_en_n = 1'b0; b1_en_n = 1'b1; b2_en_n = 1'b1;
        #1 chk("R7 a_drv", {11'd0, a_drv}, 12'd1);
        chk("R7 b1_drv off", {11'd0, b1_drv}, 12'd0);
        chk("R7 word while released", b1_out, 12'h0F1);
        b1_en_n = 1'b0;
        #1 chk("R8 b1 on", {11'd0, b1_drv}, 12'd1);
        chk("R8 b2 stays off", {11'd0, b2_drv}, 12'd0);
        b2_en_n = 1'b0; b1_en_n = 1'b1;
        #1 chk("R8 b2 on", {11'd0, b2_drv}, 12'd1);
        chk("R8 b1 off", {11'd0, b1_drv}, 12'd0);
        chk("R8 b2 word", b2_out, 12'h9C4);
        a_en_n = 1'b1;
        #1 chk("R7 a off", {11'd0, a_drv}, 12'd0);
        step();
    endtask

    task automatic t_concurrent();
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] va, v1, v2;
            va = 12'h100 + 12'(k * 17);
            v1 = 12'h200 + 12'(k * 5);
            v2 = 12'h400 + 12'(k * 9);
            a_in = va; b1_in = v1; b2_in = v2;
            ld_a2b1 = (k % 2 == 0); ld_a2b2 = (k % 2 == 1);
            ld_b1a = 1'b1; ld_b2a = 1'b1;
            step();
            ld_a2b1 = 1'b0; ld_a2b2 = 1'b0; ld_b1a = 1'b0; ld_b2a = 1'b0;
            a_in = ~va; b1_in = ~v1; b2_in = ~v2;
            a_pick = k[0];
            step();
            if (k % 2 == 0) chk("R9 b1 loaded", b1_out, va);
            else            chk("R9 b2 loaded", b2_out, va);
            chk("R9 a picked", a_out, k[0] ? v1 : v2);
        end
    endtask

    initial begin
        step();
        t_reset();
        t_transparent();
        t_capture();
        t_b_side();
        t_pick();
        t_enables();
        t_concurrent();
        t_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule